// File: doc/BRIEF.md
# Retriggerable Resettable Pulse Stretcher

This block is a two-channel, clock-driven one-shot. Each channel watches a pair of trigger inputs of opposite polarity, one active-high and one active-low. When their combined condition becomes true, the channel drives its true output high for a programmed number of clock cycles. A complementary output always carries the inverse. A fresh trigger that arrives while a pulse is running reloads the interval, so the pulse is stretched. An active-low clear ends the pulse at once.

The pulse length comes from a per-channel count input. The count is captured at the moment of triggering. The trigger inputs respond to levels that are held for at least one clock. They are assumed to be synchronous already. Retriggering can be suppressed outside the block by wiring the true output back to the active-low trigger input.

Top module: `dual_oneshot`

## Requirements
- R1: While synchronous reset `rst` is high, and directly after it, every channel has `pulse` = 0 and `pulse_n` = 1.
- R2: A channel fires when `trig_hi` rises while `trig_lo_n` is low. `pulse` is then high after the next clock edge, for exactly N consecutive cycles, where N is the value of `pulse_len` for that channel at the firing edge. Channel i's length is `pulse_len[i*CNT_W +: CNT_W]`.
- R3: A channel also fires when `trig_lo_n` falls while `trig_hi` is high, with the same pulse timing as R2.
- R4: Holding the trigger condition true without a new transition does not start another pulse.
- R5: A trigger during a running pulse reloads the interval. `pulse` stays high and ends N cycles after the last trigger.
- R6: While `clr_n` is low, `pulse` is low in the same cycle, without waiting for a clock edge. The remaining interval is discarded.
- R7: Trigger transitions while `clr_n` is low are ignored. A trigger condition still true when clear is released (or when reset ends) does not start a pulse until a new transition occurs.
- R8: Firing with N = 0 produces no pulse.
- R9: `pulse_n` is always the inverse of `pulse`.
- R10: The channels are independent and can run overlapping pulses.
- R11: With `trig_lo_n` fed from the channel's own `pulse`, further transitions on `trig_hi` during the pulse do not extend it.
- R12: Changing `pulse_len` during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | NUM_CH | Per-channel direct clear, active low |
| trig_lo_n | input | NUM_CH | Active-low trigger per channel |
| trig_hi | input | NUM_CH | Active-high trigger per channel |
| pulse_len | input | NUM_CH*CNT_W | Per-channel pulse length in cycles |
| pulse | output | NUM_CH | True pulse output per channel |
| pulse_n | output | NUM_CH | Complementary pulse output per channel |

## Verification
The bench builds the block with its defaults: two channels and an 8-bit length field. Lengths of 0, 2, 3 and 5 cycles are used, so the end of a pulse, a reload in the middle of a pulse, and the zero case all fall within a few cycles of each other. With two channels, overlapping pulses and lengths that differ per channel can be tested. Channel 1 is also run with its own output wired back to its active-low trigger, which exercises the non-retriggerable configuration.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Combined trigger level: active-high input asserted and active-low input asserted.
  function automatic logic trig_level(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction

  // Rising transition of a level against its registered copy.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic trig_hi,
  input  logic trig_lo_n,
  output logic cond,
  output logic fire
);

  logic cond_q;

  assign cond = trig_level(trig_hi, trig_lo_n);

  // The registered copy tracks the level even during clear, so a held
  // condition never looks like a new transition after release.
  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b1;
    else     cond_q <= cond;
  end

  assign fire = rise_of(cond, cond_q) & clr_n;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain;

  function automatic logic [CNT_W-1:0] next_remain(
    input logic             ld,
    input logic [CNT_W-1:0] ld_val,
    input logic [CNT_W-1:0] cur
  );
    if (ld)                return ld_val;
    else if (cur != ZERO)  return cur - ONE;
    else                   return ZERO;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !clr_n) remain <= ZERO;
    else               remain <= next_remain(fire, len, remain);
  end

  assign busy = (remain != ZERO);

endmodule

// File: rtl/oneshot_chan.sv
module oneshot_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             trig_hi,
  input  logic             trig_lo_n,
  input  logic [CNT_W-1:0] len,
  output logic             cond,
  output logic             fire,
  output logic             pulse,
  output logic             pulse_n
);

  logic busy;

  oneshot_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .trig_hi   (trig_hi),
    .trig_lo_n (trig_lo_n),
    .cond      (cond),
    .fire      (fire)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .fire  (fire),
    .len   (len),
    .busy  (busy)
  );

  // Clear gates the output directly so the pulse ends within the cycle.
  assign pulse   = busy & clr_n;
  assign pulse_n = ~pulse;

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       clr_n,
  input  logic [NUM_CH-1:0]       trig_lo_n,
  input  logic [NUM_CH-1:0]       trig_hi,
  input  logic [NUM_CH*CNT_W-1:0] pulse_len,
  output logic [NUM_CH-1:0]       pulse,
  output logic [NUM_CH-1:0]       pulse_n
);

  // Internal events brought out by name for the checker.
  logic [NUM_CH-1:0] cond_w;
  logic [NUM_CH-1:0] fire_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    oneshot_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .clr_n     (clr_n[c]),
      .trig_hi   (trig_hi[c]),
      .trig_lo_n (trig_lo_n[c]),
      .len       (pulse_len[c*CNT_W +: CNT_W]),
      .cond      (cond_w[c]),
      .fire      (fire_w[c]),
      .pulse     (pulse[c]),
      .pulse_n   (pulse_n[c])
    );
  end

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       clr_n,
  input logic [NUM_CH-1:0]       cond,
  input logic [NUM_CH-1:0]       fire,
  input logic [NUM_CH*CNT_W-1:0] pulse_len,
  input logic [NUM_CH-1:0]       pulse,
  input logic [NUM_CH-1:0]       pulse_n
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    wire [CNT_W-1:0] len_c = pulse_len[c*CNT_W +: CNT_W];

    p_complement_r9: assert property (@(posedge clk) disable iff (rst)
      pulse_n[c] == ~pulse[c]);

    p_clear_low_r6: assert property (@(posedge clk) disable iff (rst)
      !clr_n[c] |-> !pulse[c]);

    // Covers a first trigger (R2/R3) and a reload during a pulse (R5).
    p_fire_starts_r2: assert property (@(posedge clk) disable iff (rst)
      (fire[c] && len_c != '0) |=> (pulse[c] || !clr_n[c]));

    p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
      (fire[c] && len_c == '0) |=> !pulse[c]);

    p_rise_needs_fire_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse[c]) |-> $past(fire[c]));

    p_release_held_r7: assert property (@(posedge clk) disable iff (rst)
      (clr_n[c] && $past(!clr_n[c]) && $past(cond[c])) |-> !fire[c]);
  end

endmodule

bind dual_oneshot oneshot_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_n     (clr_n),
  .cond      (cond_w),
  .fire      (fire_w),
  .pulse_len (pulse_len),
  .pulse     (pulse),
  .pulse_n   (pulse_n)
);

// File: tb/test_dual_oneshot.sv
module test_dual_oneshot;

  localparam int NUM_CH = 2;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CH-1:0] clr_n  = '1;
  logic [NUM_CH-1:0] hi     = '0;
  logic [NUM_CH-1:0] lo_drv = '1;
  logic fb = 1'b0;
  logic [CNT_W-1:0] len0 = 8'd3;
  logic [CNT_W-1:0] len1 = 8'd5;
  logic [NUM_CH-1:0] pulse, pulse_n, trig_lo_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  assign trig_lo_n = {fb ? pulse[1] : lo_drv[1], lo_drv[0]};

  dual_oneshot #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_dual_oneshot (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .trig_lo_n (trig_lo_n),
    .trig_hi   (trig_hi_w),
    .pulse_len ({len1, len0}),
    .pulse     (pulse),
    .pulse_n   (pulse_n)
  );
  wire [NUM_CH-1:0] trig_hi_w = hi;

  // Driver side: queue the expectation for the coming edge, advance.
  task automatic tick(input string req, input logic [1:0] e);
    item_t it;
    it.exp = e;
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // Monitor: compare outputs after each edge against the queued item.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pulse !== it.exp) begin
        errors++;
        $display("FAIL %s: pulse=%b expected %b", it.req, pulse, it.exp);
      end
      checks++;
      if (pulse_n !== ~it.exp) begin
        errors++;
        $display("FAIL R9: pulse_n=%b expected %b", pulse_n, ~it.exp);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    tick("R1", 2'b00);
    rst = 1'b0;
    tick("R1", 2'b00);

    // R2: ch0 active-high rises while active-low held low, N=3
    lo_drv[0] = 1'b0;
    tick("R2", 2'b00);
    hi[0] = 1'b1;
    tick("R2", 2'b01); tick("R2", 2'b01); tick("R2", 2'b01);
    tick("R2", 2'b00);
    tick("R4", 2'b00);   // level still held: no new pulse
    tick("R4", 2'b00);
    hi[0] = 1'b0;
    tick("R4", 2'b00);

    // R3: ch1 active-low falls while active-high held high, N=5
    hi[1] = 1'b1;
    tick("R3", 2'b00);
    lo_drv[1] = 1'b0;
    for (int k = 0; k < 5; k++) tick("R3", 2'b10);
    tick("R3", 2'b00);
    lo_drv[1] = 1'b1; hi[1] = 1'b0;
    tick("R3", 2'b00);

    // R5: retrigger on ch0 reloads the interval
    hi[0] = 1'b1; tick("R5", 2'b01);
    hi[0] = 1'b0; tick("R5", 2'b01);
    hi[0] = 1'b1; tick("R5", 2'b01);
    tick("R5", 2'b01); tick("R5", 2'b01);
    tick("R5", 2'b00);
    hi[0] = 1'b0; tick("R5", 2'b00);

    // R6: clear ends the pulse within the cycle
    hi[0] = 1'b1; tick("R6", 2'b01);
    hi[0] = 1'b0;
    clr_n[0] = 1'b0;
    #1;
    checks++;
    if (pulse[0] !== 1'b0) begin
      errors++;
      $display("FAIL R6: immediate pulse=%b expected 0", pulse[0]);
    end
    tick("R6", 2'b00);
    clr_n[0] = 1'b1;
    tick("R6", 2'b00);   // remaining interval discarded
    tick("R6", 2'b00);

    // R7: transition during clear ignored, held level on release ignored
    clr_n[0] = 1'b0;
    hi[0] = 1'b1; tick("R7", 2'b00);
    tick("R7", 2'b00);
    clr_n[0] = 1'b1; tick("R7", 2'b00);
    tick("R7", 2'b00);
    hi[0] = 1'b0; tick("R7", 2'b00);
    hi[0] = 1'b1; tick("R7", 2'b01);
    tick("R7", 2'b01); tick("R7", 2'b01);
    tick("R7", 2'b00);
    hi[0] = 1'b0; tick("R7", 2'b00);

    // R8: zero length gives no pulse
    len0 = 8'd0;
    hi[0] = 1'b1; tick("R8", 2'b00);
    tick("R8", 2'b00);
    hi[0] = 1'b0; tick("R8", 2'b00);
    len0 = 8'd3;

    // R10 + R12: overlapping channels, length change mid-pulse
    len1 = 8'd2;
    hi[0] = 1'b1; tick("R10", 2'b01);
    len0 = 8'd7;
    hi[1] = 1'b1; lo_drv[1] = 1'b0;
    tick("R10", 2'b11);
    tick("R12", 2'b11);
    tick("R12", 2'b00);
    hi[0] = 1'b0; hi[1] = 1'b0; lo_drv[1] = 1'b1;
    len0 = 8'd3; len1 = 8'd5;
    tick("R10", 2'b00);

    // R11: ch1 output fed back to its active-low trigger
    fb = 1'b1;
    tick("R11", 2'b00);
    hi[1] = 1'b1; tick("R11", 2'b10);
    hi[1] = 1'b0; tick("R11", 2'b10);
    hi[1] = 1'b1; tick("R11", 2'b10);
    hi[1] = 1'b0; tick("R11", 2'b10);
    tick("R11", 2'b10);
    tick("R11", 2'b00);
    tick("R11", 2'b00);

    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule